// File: doc/BRIEF.md
# Clock Output Control Register Bank

This block is the digital control core of a clock generator with many outputs. At power-up it captures five frequency-select straps from pins that later serve as clock outputs. It then hands those pins back to their output drivers. It also holds five byte-wide control registers that a serial bus slave writes one byte at a time. From the straps and the registers it produces a 5-bit frequency code, a spread-spectrum enable, a global high-impedance request and a PLL enable. It also gates 25 clock outputs: four CPU, three IOAPIC, eleven PCI, three 66 MHz, two reference, one fixed 48 MHz and one selectable 24/48 MHz.

Each output has its own enable bit. A stopped output is held low, never floated. An enable change is carried into the domain of the output's own clock on falling edges, so the output only starts or stops while that clock is low. An asynchronous active-low power-down input forces every output low at once and drops the PLL enable. Some bits of bytes 3 and 4 are read-only and return the inverted captured straps.

The strap machine has three states. ST_CAPTURE is the state after reset. On the first clock it latches the straps and takes transition T_LATCH to ST_HOLD. ST_HOLD counts HOLD_CYC clocks and then takes transition T_RELEASE to ST_RUN. ST_RUN keeps the straps frozen and drives the pin output enable high until the next reset.

Top module: `clkgen_ctrl`

## Requirements
- R1: The straps are latched on the first clock after reset. `strap_oe` is 0 during reset and is 1 from a few clocks later onward. Later changes on `strap_i` never alter the latched value.
- R2: After reset, byte 0 reads 0x00. Byte 1 reads 0xFE (bit 0 is reserved and reads 0), and byte 2 reads 0xFF. In bytes 1 to 4, every writable enable bit is 1, so every output runs.
- R3: When byte 0 bit 3 is 0, `fsel` equals the latched straps. When it is 1, `fsel` = {b0[2], b0[7], b0[6], b0[5], b0[4]} (MSB first).
- R4: `spread_en` follows byte 0 bit 1, and `out_hiz` follows byte 0 bit 0.
- R5: Each enable bit, when 0, holds its output low with no toggling, and when 1, lets the output follow its source clock. Byte 1 bits 7,6,5,4 enable CPU1,2,3,0, and bits 3,2,1 enable IOAPIC0,1,2. Byte 2 bit k enables PCI k (k = 0..7). Byte 4 bits 1,2,3 enable PCI8,9,10. Byte 3 bits 7,6,5 enable 66 MHz outputs 0,1,2, and bits 3,2 enable REF0,1. Byte 4 bit 7 enables the 24/48 output and bit 6 the fixed 48 MHz output.
- R6: An output starts or stops only while its source clock is low, so no shortened high pulse is ever emitted.
- R7: Byte 3 bits 4,1,0 read the inverted latched strap bits 1,3,2. Byte 4 bits 5,0 read the inverted strap bits 0,4. Writes do not change these bits. The writable masks are 0xEC for byte 3 and 0xCE for byte 4, with byte 4 bit 4 reading 0.
- R8: Writes to addresses 5, 6 and 7 are ignored. Those addresses read 0x00.
- R9: While `pwrdn_n` is 0, every clock output is low and `pll_en` is 0, without waiting for a clock. Outputs resume when it returns to 1.
- R10: The 24/48 output follows `c48_ci` when `sel24` is 0 and `c24_ci` when `sel24` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for register writes and the strap machine |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| strap_i | input | 5 | Frequency-select strap levels on shared pins |
| strap_oe | output | 1 | Shared pins may drive their clock outputs |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | 3 | Byte read address |
| rd_data | output | 8 | Byte read data (combinational) |
| pwrdn_n | input | 1 | Asynchronous active-low power-down |
| sel24 | input | 1 | 24/48 output select, 1 = 24 MHz |
| cpu_ci | input | 1 | CPU source clock |
| apic_ci | input | 1 | IOAPIC source clock |
| pci_ci | input | 1 | PCI source clock |
| m66_ci | input | 1 | 66 MHz source clock |
| ref_ci | input | 1 | Reference source clock |
| c48_ci | input | 1 | 48 MHz source clock |
| c24_ci | input | 1 | 24 MHz source clock |
| cpu_co | output | 4 | Gated CPU clocks |
| apic_co | output | 3 | Gated IOAPIC clocks |
| pci_co | output | 11 | Gated PCI clocks |
| m66_co | output | 3 | Gated 66 MHz clocks |
| ref_co | output | 2 | Gated reference clocks |
| c48_co | output | 1 | Gated fixed 48 MHz clock |
| c2448_co | output | 1 | Gated 24/48 MHz clock |
| fsel | output | 5 | Frequency-select code |
| spread_en | output | 1 | Spread-spectrum enable |
| out_hiz | output | 1 | Request to float all clock output drivers |
| pll_en | output | 1 | PLL enable |

## Verification
A wrong strap latch or a wrong source bit shows up as a wrong `fsel` value or wrong read-only bits within one control clock of the read. A wrong bit in the enable mapping shows up in the first measurement window: the wrong output stops toggling, or an output fails to stop. A broken synchronizer shows up as a high pulse shorter than half a period on a single edge. A write that lands in a reserved address shows up as changed readback or stopped outputs. An incomplete power-down shows up as a rising edge on any output while `pwrdn_n` is low.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/1ps
package clkctl_pkg;
    localparam int ADDR_W   = 3;
    localparam int NBYTES   = 5;
    localparam int FS_W     = 5;
    localparam int N_CPU    = 4;
    localparam int N_APIC   = 3;
    localparam int N_PCI    = 11;
    localparam int N_M66    = 3;
    localparam int N_REF    = 2;
    localparam int IDX_CPU  = 0;
    localparam int IDX_APIC = IDX_CPU + N_CPU;
    localparam int IDX_PCI  = IDX_APIC + N_APIC;
    localparam int IDX_M66  = IDX_PCI + N_PCI;
    localparam int IDX_REF  = IDX_M66 + N_M66;
    localparam int IDX_48   = IDX_REF + N_REF;
    localparam int IDX_2448 = IDX_48 + 1;
    localparam int NUM_OUT  = IDX_2448 + 1;

    typedef enum logic [1:0] {
        ST_CAPTURE = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RUN     = 2'd2
    } strap_state_t;

    function automatic logic [7:0] wmask(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'hFE;
            2:       return 8'hFF;
            3:       return 8'hEC;
            4:       return 8'hCE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] rstval(input int idx);
        return (idx == 0) ? 8'h00 : wmask(idx);
    endfunction
endpackage

// File: rtl/clkctl_strap_fsm.sv
`timescale 1ns/1ps
module clkctl_strap_fsm
    import clkctl_pkg::*;
#(
    parameter int HOLD_CYC = 4,
    parameter int W        = FS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] strap_i,
    output logic [W-1:0] strap_q,
    output logic         pins_oe
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    strap_state_t      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CAPTURE;
        else        state_q <= state_d;
    end

    // transitions: T_LATCH, T_RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CAPTURE: state_d = ST_HOLD;
            ST_HOLD:    if (cnt_q == CNT_W'(HOLD_CYC - 1)) state_d = ST_RUN;
            ST_RUN:     state_d = ST_RUN;
            default:    state_d = ST_CAPTURE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q <= '0;
            cnt_q   <= '0;
            pins_oe <= 1'b0;
        end else begin
            if (state_q == ST_CAPTURE) strap_q <= strap_i;
            if (state_q == ST_HOLD)    cnt_q   <= cnt_q + 1'b1;
            pins_oe <= (state_d == ST_RUN);
        end
    end

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(strap_q)); // R1
    AST_OE_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        pins_oe |-> (state_q == ST_RUN)); // R1
endmodule

// File: rtl/clkctl_regs.sv
`timescale 1ns/1ps
module clkctl_regs
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [FS_W-1:0]   strap_q,
    output logic [FS_W-1:0]   fsel,
    output logic              spread_en,
    output logic              out_hiz,
    output logic [NUM_OUT-1:0] en_vec
);
    logic [NBYTES-1:0][7:0] bq;

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bq[gi] <= rstval(gi);
            else if (wr_en && wr_addr == ADDR_W'(gi))
                bq[gi] <= wr_data & wmask(gi);
        end
    end

    logic [FS_W-1:0] reg_code;
    assign reg_code  = {bq[0][2], bq[0][7], bq[0][6], bq[0][5], bq[0][4]};
    assign fsel      = bq[0][3] ? reg_code : strap_q;
    assign spread_en = bq[0][1];
    assign out_hiz   = bq[0][0];

    always_comb begin
        en_vec = '0;
        en_vec[IDX_CPU + 1]  = bq[1][7];
        en_vec[IDX_CPU + 2]  = bq[1][6];
        en_vec[IDX_CPU + 3]  = bq[1][5];
        en_vec[IDX_CPU + 0]  = bq[1][4];
        en_vec[IDX_APIC + 0] = bq[1][3];
        en_vec[IDX_APIC + 1] = bq[1][2];
        en_vec[IDX_APIC + 2] = bq[1][1];
        for (int k = 0; k < 8; k++) en_vec[IDX_PCI + k] = bq[2][k];
        en_vec[IDX_PCI + 8]  = bq[4][1];
        en_vec[IDX_PCI + 9]  = bq[4][2];
        en_vec[IDX_PCI + 10] = bq[4][3];
        en_vec[IDX_M66 + 0]  = bq[3][7];
        en_vec[IDX_M66 + 1]  = bq[3][6];
        en_vec[IDX_M66 + 2]  = bq[3][5];
        en_vec[IDX_REF + 0]  = bq[3][3];
        en_vec[IDX_REF + 1]  = bq[3][2];
        en_vec[IDX_2448]     = bq[4][7];
        en_vec[IDX_48]       = bq[4][6];
    end

    always_comb begin
        unique case (rd_addr)
            3'd0:    rd_data = bq[0];
            3'd1:    rd_data = bq[1];
            3'd2:    rd_data = bq[2];
            3'd3:    rd_data = bq[3] | {3'b000, ~strap_q[1], 2'b00, ~strap_q[3], ~strap_q[2]};
            3'd4:    rd_data = bq[4] | {2'b00, ~strap_q[0], 4'b0000, ~strap_q[4]};
            default: rd_data = 8'h00;
        endcase
    end

    AST_HOLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) >= NBYTES) |=> $stable(bq)); // R8
endmodule

// File: rtl/clkctl_gate.sv
`timescale 1ns/1ps
module clkctl_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic pwrdn_n,
    input  logic en_req,
    output logic clk_o
);
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], en_req};
    end

    assign clk_o = clk_i & sync_q[SYNC_STAGES-1] & pwrdn_n;

    if (SYNC_STAGES == 2) begin : g_chk
        AST_START_FOLLOWS_REQ: assert property (@(negedge clk_i) disable iff (!rst_n)
            $rose(sync_q[1]) |-> $past(en_req, 2)); // R6
    end
endmodule

// File: rtl/clkgen_ctrl.sv
`timescale 1ns/1ps
module clkgen_ctrl
    import clkctl_pkg::*;
#(
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FS_W-1:0]   strap_i,
    output logic              strap_oe,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              pwrdn_n,
    input  logic              sel24,
    input  logic              cpu_ci,
    input  logic              apic_ci,
    input  logic              pci_ci,
    input  logic              m66_ci,
    input  logic              ref_ci,
    input  logic              c48_ci,
    input  logic              c24_ci,
    output logic [N_CPU-1:0]  cpu_co,
    output logic [N_APIC-1:0] apic_co,
    output logic [N_PCI-1:0]  pci_co,
    output logic [N_M66-1:0]  m66_co,
    output logic [N_REF-1:0]  ref_co,
    output logic              c48_co,
    output logic              c2448_co,
    output logic [FS_W-1:0]   fsel,
    output logic              spread_en,
    output logic              out_hiz,
    output logic              pll_en
);
    logic [FS_W-1:0]    strap_q;
    logic [NUM_OUT-1:0] en_vec;
    logic [NUM_OUT-1:0] src_clk;
    logic [NUM_OUT-1:0] gated;
    logic               sel_src;

    clkctl_strap_fsm #(.HOLD_CYC(HOLD_CYC), .W(FS_W)) u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_i),
        .strap_q (strap_q),
        .pins_oe (strap_oe)
    );

    clkctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .strap_q   (strap_q),
        .fsel      (fsel),
        .spread_en (spread_en),
        .out_hiz   (out_hiz),
        .en_vec    (en_vec)
    );

    assign sel_src = sel24 ? c24_ci : c48_ci;
    assign src_clk = {sel_src, c48_ci, {N_REF{ref_ci}}, {N_M66{m66_ci}},
                      {N_PCI{pci_ci}}, {N_APIC{apic_ci}}, {N_CPU{cpu_ci}}};

    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_out
        clkctl_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk_i   (src_clk[gi]),
            .rst_n   (rst_n),
            .pwrdn_n (pwrdn_n),
            .en_req  (en_vec[gi]),
            .clk_o   (gated[gi])
        );
    end

    assign cpu_co   = gated[IDX_CPU  +: N_CPU];
    assign apic_co  = gated[IDX_APIC +: N_APIC];
    assign pci_co   = gated[IDX_PCI  +: N_PCI];
    assign m66_co   = gated[IDX_M66  +: N_M66];
    assign ref_co   = gated[IDX_REF  +: N_REF];
    assign c48_co   = gated[IDX_48];
    assign c2448_co = gated[IDX_2448];
    assign pll_en   = pwrdn_n;

    AST_FSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && strap_oe) |=> $stable(fsel)); // R3
    AST_PWRDN_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |-> ({c2448_co, c48_co, ref_co, m66_co, pci_co, apic_co, cpu_co} == '0)); // R9
endmodule

// File: tb/sim_clkgen_ctrl.sv
`timescale 1ns/1ps
module sim_clkgen_ctrl;
    localparam int NO = 25;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] strap_i = '0;
    logic strap_oe;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic pwrdn_n = 1'b1, sel24 = 1'b0;
    logic oclk = 1'b0, c24 = 1'b0;
    logic [3:0] cpu_co; logic [2:0] apic_co; logic [10:0] pci_co;
    logic [2:0] m66_co; logic [1:0] ref_co; logic c48_co, c2448_co;
    logic [4:0] fsel; logic spread_en, out_hiz, pll_en;
    logic [NO-1:0] outv;

    int total = 0, bad = 0;
    int rises [NO];
    int badrun [NO];
    logic [NO-1:0] lastv;
    logic [7:0] eb [5];
    logic [4:0] sl;

    always #2 clk = ~clk;
    always #20 oclk = ~oclk;
    always #40 c24 = ~c24;

    clkgen_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .strap_oe(strap_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwrdn_n(pwrdn_n), .sel24(sel24),
        .cpu_ci(oclk), .apic_ci(oclk), .pci_ci(oclk), .m66_ci(oclk),
        .ref_ci(oclk), .c48_ci(oclk), .c24_ci(c24),
        .cpu_co(cpu_co), .apic_co(apic_co), .pci_co(pci_co), .m66_co(m66_co),
        .ref_co(ref_co), .c48_co(c48_co), .c2448_co(c2448_co),
        .fsel(fsel), .spread_en(spread_en), .out_hiz(out_hiz), .pll_en(pll_en)
    );

    assign outv = {c2448_co, c48_co, ref_co, m66_co, pci_co, apic_co, cpu_co};

    function automatic logic [7:0] msk(input int a);
        case (a)
            0: return 8'hFF; 1: return 8'hFE; 2: return 8'hFF;
            3: return 8'hEC; 4: return 8'hCE; default: return 8'h00;
        endcase
    endfunction

    // R5 mapping: output index -> byte*8 + bit
    function automatic int map_of(input int idx);
        case (idx)
            0: return 8+4;  1: return 8+7;  2: return 8+6;  3: return 8+5;
            4: return 8+3;  5: return 8+2;  6: return 8+1;
            18: return 24+7; 19: return 24+6; 20: return 24+5;
            21: return 24+3; 22: return 24+2;
            15: return 32+1; 16: return 32+2; 17: return 32+3;
            23: return 32+6; 24: return 32+7;
            default: return 16 + (idx - 7);
        endcase
    endfunction

    function automatic logic [NO-1:0] exp_en();
        logic [NO-1:0] e;
        for (int i = 0; i < NO; i++) begin
            int m = map_of(i);
            e[i] = eb[m / 8][m % 8];
        end
        return e;
    endfunction

    function automatic logic [7:0] rd_exp(input int a);
        case (a)
            0, 1, 2: return eb[a];
            3: return eb[3] | {3'b000, ~sl[1], 2'b00, ~sl[3], ~sl[2]};
            4: return eb[4] | {2'b00, ~sl[0], 4'b0000, ~sl[4]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 5) eb[a] = d & msk(a);
    endtask

    task automatic rdchk(input string req, input int a);
        @(negedge clk);
        rd_addr = 3'(a);
        #1;
        chk(req, {24'h0, rd_data}, {24'h0, rd_exp(a)});
    endtask

    task automatic measure();
        logic [NO-1:0] p, v;
        int rl [NO];
        bit st [NO];
        @(negedge clk);
        #0.5;
        for (int b = 0; b < NO; b++) begin rises[b] = 0; badrun[b] = 0; rl[b] = 0; st[b] = 0; end
        p = outv;
        for (int k = 0; k < 400; k++) begin
            #1;
            v = outv;
            for (int b = 0; b < NO; b++) begin
                int hi = (b == 24 && sel24) ? 40 : 20;
                if (v[b] && !p[b]) begin rises[b]++; rl[b] = 1; st[b] = 1; end
                else if (v[b] && p[b]) rl[b]++;
                else if (!v[b] && p[b] && st[b] && rl[b] != hi) badrun[b]++;
            end
            p = v;
        end
        lastv = p;
    endtask

    task automatic check_all(input string req, input logic [NO-1:0] en);
        for (int b = 0; b < NO; b++) begin
            int er = !en[b] ? 0 : ((b == 24 && sel24) ? 5 : 10);
            chk(req, rises[b], er);
            chk(req, badrun[b], 0);
        end
    endtask

    task automatic do_reset(input logic [4:0] s);
        @(negedge clk);
        rst_n = 1'b0; strap_i = s;
        #20;
        chk("R1 reset oe", {31'h0, strap_oe}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        sl = s;
        for (int a = 0; a < 5; a++) eb[a] = (a == 0) ? 8'h00 : msk(a);
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [4:0] straps [4] = '{5'b10110, 5'b01001, 5'b00000, 5'b11111};
        for (int i = 0; i < 4; i++) begin
            do_reset(straps[i]);
            chk("R1 oe", {31'h0, strap_oe}, 1);
            chk("R1 fsel", {27'h0, fsel}, {27'h0, straps[i]});
            chk("R4 reset spread", {31'h0, spread_en}, 0);
            chk("R4 reset hiz", {31'h0, out_hiz}, 0);
            for (int a = 0; a < 5; a++) rdchk(a >= 3 ? "R7 readback" : "R2 readback", a);
            strap_i = ~straps[i];
            #40;
            chk("R1 strap frozen", {27'h0, fsel}, {27'h0, straps[i]});
        end
        #100;
        measure();
        check_all("R2 all running", exp_en());

        // R3: register code sweep
        for (int c = 0; c < 32; c++) begin
            logic [4:0] cd = 5'(c);
            wr(0, {cd[3:0], 1'b1, cd[4], 2'b00});
            chk("R3 reg code", {27'h0, fsel}, {27'h0, cd});
        end
        wr(0, 8'hF4);
        chk("R3 strap source", {27'h0, fsel}, {27'h0, sl});

        // R4
        wr(0, 8'h02);
        chk("R4 spread", {30'h0, spread_en, out_hiz}, 2);
        wr(0, 8'h01);
        chk("R4 hiz", {30'h0, spread_en, out_hiz}, 1);
        wr(0, 8'h00);

        // R7: read-only strap bits survive writes
        wr(3, 8'h00); rdchk("R7 byte3", 3);
        wr(4, 8'h00); rdchk("R7 byte4", 4);
        wr(3, 8'hFF); rdchk("R7 byte3 ones", 3);
        wr(4, 8'hFF); rdchk("R7 byte4 ones", 4);

        // R5: walk a single zero through every enable bit
        for (int a = 1; a < 5; a++) begin
            for (int j = 0; j < 8; j++) begin
                wr(a, 8'hFF & ~(8'h01 << j));
                #100;
                measure();
                check_all("R5 enable map", exp_en());
                rdchk("R5 readback", a);
                wr(a, 8'hFF);
            end
        end

        // R6: stop mid-window, no runt pulse
        #100;
        fork
            measure();
            begin #150; wr(2, 8'hFE); end
        join
        for (int b = 0; b < NO; b++) chk("R6 no runt on stop", badrun[b], 0);
        chk("R6 stopped low", {31'h0, lastv[7]}, 0);
        fork
            measure();
            begin #150; wr(2, 8'hFF); end
        join
        for (int b = 0; b < NO; b++) chk("R6 no runt on start", badrun[b], 0);

        // R8: writes to unused addresses
        wr(5, 8'h00); wr(6, 8'h00); wr(7, 8'h00);
        for (int a = 0; a < 8; a++) rdchk("R8 readback", a);
        #100;
        measure();
        check_all("R8 outputs kept", exp_en());

        // R9: power-down
        @(negedge clk);
        pwrdn_n = 1'b0;
        #1;
        chk("R9 pll_en", {31'h0, pll_en}, 0);
        chk("R9 immediate low", {7'h0, outv}, 0);
        measure();
        check_all("R9 powered down", '0);
        pwrdn_n = 1'b1;
        #100;
        measure();
        check_all("R9 resumed", exp_en());
        chk("R9 pll_en back", {31'h0, pll_en}, 1);

        // R10: 24/48 select
        sel24 = 1'b1;
        #200;
        measure();
        check_all("R10 sel 24", exp_en());
        sel24 = 1'b0;
        #200;
        measure();
        check_all("R10 sel 48", exp_en());

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule